// File: doc/BRIEF.md
# Timer Capture / Compare / PWM Channel

One channel of a general-purpose timer. A shared free-running counter supplies its current value and a one-cycle overflow strobe. Depending on its configuration the channel either records the counter value when a chosen edge appears on its input pin (input capture), or drives its output pin when the counter reaches a stored value (output compare / edge-aligned PWM). When it drives the pin, it can also toggle the pin on every counter overflow.

Configuration is a single write strobe that loads four fields together: a 2-bit mode, a 2-bit edge/action select, a toggle-on-overflow bit and a force-full-duty bit. A separate strobe writes the compare/capture value register. The channel flag is set by each capture or compare match and cleared by a write-one-to-clear strobe. Edge/action select 00 leaves the pin to general-purpose logic and only presets the level that the output starts from. The force-full-duty request is applied at a counter overflow, so a PWM period is never cut short.

Top module: `tmr_channel`

## Requirements
- R1: With edge/action select 00, pin_oe is 0 and pin_out equals mode bit 0. That level is also loaded as the channel's output state, so an output mode entered later starts from it.
- R2: Capture mode is mode 00 with a nonzero edge/action select. In this mode pin_oe and pin_out are 0. Select 01 captures on rising edges only, 10 on falling edges only and 11 on both.
- R3: pin_in passes through a two-flop synchronizer. A change set up before clock edge k is captured at edge k+2. At that edge chan_val takes the cnt_val present before it and chan_flag is set.
- R4: Output modes are mode 01 and modes 1X with a nonzero select. In these modes pin_oe is 1. At an edge where cnt_val equals chan_val, the output toggles (01), clears (10) or sets (11), and chan_flag is set.
- R5: In an output mode with toggle-on-overflow set, each clock edge with cnt_ovf high toggles the output state.
- R6: When toggle-on-overflow is set and cnt_ovf coincides with a compare match, only the toggle is applied. The flag is still set.
- R7: In capture mode, toggle-on-overflow and overflows leave the output state unchanged. The held state appears on pin_out once an output mode is selected.
- R8: In an output mode with toggle-on-overflow set, a full-duty request takes effect at the next cnt_ovf edge and then holds pin_out at 1. Clearing the request releases the output only at the following cnt_ovf edge.
- R9: flag_clr clears chan_flag at the next edge. A capture or match in the same cycle wins and leaves the flag set.
- R10: Synchronous active-low reset clears all four configuration fields, the value register and the flag. After reset, pin_out and pin_oe are 0.
- R11: val_we loads val_wdata into chan_val. A capture in the same cycle wins.
- R12: cfg_we loads all four configuration fields at one clock edge. They take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_ovf | input | 1 | Counter overflow strobe, one cycle |
| cfg_we | input | 1 | Load configuration fields |
| cfg_mode | input | 2 | Mode field |
| cfg_esel | input | 2 | Edge / action select field |
| cfg_tov | input | 1 | Toggle-on-overflow field |
| cfg_full | input | 1 | Force full duty request |
| val_we | input | 1 | Write compare/capture value |
| val_wdata | input | CNT_W | Value to write |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| pin_in | input | 1 | Asynchronous channel pin input |
| pin_out | output | 1 | Channel pin output level |
| pin_oe | output | 1 | Channel drives the pin |
| chan_flag | output | 1 | Capture / match flag |
| chan_val | output | CNT_W | Compare/capture value register |

## Verification
The hardest situations to reach are those where two events fall in the same cycle. One is an overflow strobe that lands on a compare match. The other is a full-duty request written in the middle of a period, which must wait for the next overflow both to start and to stop. The bench reaches both with directed sequences: it holds cnt_val at the stored value while pulsing cnt_ovf, and it writes the full-duty bit between overflows. It then spends several thousand cycles of seeded random configuration, counter, pin and strobe traffic. The counter is kept in a narrow range so that matches, captures and collisions with writes and clears happen often.

// File: rtl/tch_pkg.sv
// Shared types for the timer channel.
// Assumes: edge/action select bit 0 = rising/toggle, bit 1 = falling/clear.
package tch_pkg;
    typedef enum logic [1:0] {
        ESEL_OFF = 2'b00,
        ESEL_A   = 2'b01,
        ESEL_B   = 2'b10,
        ESEL_C   = 2'b11
    } esel_e;

    typedef struct packed {
        logic [1:0] mode;
        esel_e      esel;
        logic       tov;
        logic       fullduty;
    } cfg_t;

    localparam cfg_t CFG_RST = '{mode: 2'b00, esel: ESEL_OFF, tov: 1'b0, fullduty: 1'b0};

    // Channel drives the pin: compare or PWM mode with a nonzero select.
    function automatic logic is_out_mode(cfg_t c);
        return (c.esel != ESEL_OFF) && (c.mode != 2'b00);
    endfunction

    // Channel samples the pin: mode 00 with a nonzero select.
    function automatic logic is_cap_mode(cfg_t c);
        return (c.esel != ESEL_OFF) && (c.mode == 2'b00);
    endfunction
endpackage

// File: rtl/tch_cfg_reg.sv
// Configuration register: loads all fields at once on a write strobe.
// Assumes: synchronous active-low reset to CFG_RST.
module tch_cfg_reg
    import tch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  cfg_t wdata,
    output cfg_t q
);
    // Hold the configuration; load on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= CFG_RST;
        else if (we) q <= wdata;
    end
endmodule

// File: rtl/tch_edge_sync.sv
// Pin synchronizer and edge detector.
// Assumes: STAGES >= 2; the input is asynchronous to clk.
module tch_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop samples the raw pin.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= din;
            end
        end else begin : g_next
            // Later flops pass the value along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev;
    assign fall = ~chain[LAST] & prev;
endmodule

// File: rtl/tch_out_ctrl.sv
// Output state, match detect, overflow toggle and full-duty forcing.
// Assumes: cnt_ovf is a one-cycle strobe; full duty changes only at an overflow.
module tch_out_ctrl
    import tch_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cnt_ovf,
    output logic             cmp_hit,
    output logic             full_act,
    output logic             pin_out,
    output logic             pin_oe
);
    logic out_mode;
    logic pin_q;

    assign out_mode = is_out_mode(cfg);
    assign cmp_hit  = out_mode && (cnt_val == cmp_val);

    // Output state: preset, then overflow toggle over compare action.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b0;
        end else if (cfg.esel == ESEL_OFF) begin
            pin_q <= cfg.mode[0];
        end else if (out_mode) begin
            if (cfg.tov && cnt_ovf) begin
                pin_q <= ~pin_q;
            end else if (cmp_hit) begin
                unique case (cfg.esel)
                    ESEL_A:  pin_q <= ~pin_q;
                    ESEL_B:  pin_q <= 1'b0;
                    ESEL_C:  pin_q <= 1'b1;
                    default: pin_q <= pin_q;
                endcase
            end
        end
    end

    // Full-duty forcing follows the request only at overflow edges.
    always_ff @(posedge clk) begin
        if (!rst_n)       full_act <= 1'b0;
        else if (cnt_ovf) full_act <= cfg.fullduty && cfg.tov && out_mode;
    end

    // Pin drive: forced high while full duty is active.
    always_comb begin
        pin_oe = out_mode;
        if (out_mode)                   pin_out = pin_q | full_act;
        else if (cfg.esel == ESEL_OFF)  pin_out = cfg.mode[0];
        else                            pin_out = 1'b0;
    end
endmodule

// File: rtl/tch_val_flag.sv
// Compare/capture value register and channel flag.
// Assumes: a capture wins over a write; setting wins over clearing.
module tch_val_flag #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_evt,
    input  logic             cmp_hit,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_wdata,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] val_q,
    output logic             flag_q
);
    // Value register: capture first, then software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       val_q <= '0;
        else if (cap_evt) val_q <= cnt_val;
        else if (val_we)  val_q <= val_wdata;
    end

    // Flag: set by capture or match, cleared by strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (cap_evt || cmp_hit) flag_q <= 1'b1;
        else if (flag_clr)           flag_q <= 1'b0;
    end
endmodule

// File: rtl/tmr_channel.sv
// Top of one timer channel: capture, compare and PWM on a shared counter.
// Assumes: cnt_val and cnt_ovf come from a counter clocked by clk.
module tmr_channel
    import tch_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_ovf,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_esel,
    input  logic             cfg_tov,
    input  logic             cfg_full,
    input  logic             val_we,
    input  logic [CNT_W-1:0] val_wdata,
    input  logic             flag_clr,
    input  logic             pin_in,
    output logic             pin_out,
    output logic             pin_oe,
    output logic             chan_flag,
    output logic [CNT_W-1:0] chan_val
);
    cfg_t       cfg_wr;
    cfg_t       cfg_q;
    logic [1:0] esel_bits;
    logic       pin_rise;
    logic       pin_fall;
    logic       cap_evt;
    logic       cmp_hit;
    logic       full_act;

    assign cfg_wr    = '{mode: cfg_mode, esel: esel_e'(cfg_esel), tov: cfg_tov, fullduty: cfg_full};
    assign esel_bits = cfg_q.esel;
    assign cap_evt   = is_cap_mode(cfg_q) &&
                       ((esel_bits[0] && pin_rise) || (esel_bits[1] && pin_fall));

    tch_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wr),
        .q     (cfg_q)
    );

    tch_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    tch_out_ctrl #(.CNT_W(CNT_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg      (cfg_q),
        .cnt_val  (cnt_val),
        .cmp_val  (chan_val),
        .cnt_ovf  (cnt_ovf),
        .cmp_hit  (cmp_hit),
        .full_act (full_act),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe)
    );

    tch_val_flag #(.CNT_W(CNT_W)) u_vf (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_evt   (cap_evt),
        .cmp_hit   (cmp_hit),
        .cnt_val   (cnt_val),
        .val_we    (val_we),
        .val_wdata (val_wdata),
        .flag_clr  (flag_clr),
        .val_q     (chan_val),
        .flag_q    (chan_flag)
    );
endmodule

// File: rtl/tmr_channel_chk.sv
// Property checker for tmr_channel, attached by bind.
// Assumes: observes ports and a few internal event signals of the top.
module tmr_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic             cnt_ovf,
    input logic             cfg_we,
    input logic             flag_clr,
    input logic             pin_out,
    input logic             pin_oe,
    input logic             chan_flag,
    input logic [CNT_W-1:0] chan_val,
    input logic [1:0]       mode_q,
    input logic [1:0]       esel_q,
    input logic             tov_q,
    input logic             cap_evt,
    input logic             cmp_hit,
    input logic             full_act
);
    AST_DISCONNECTED_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (esel_q == 2'b00) |-> (!pin_oe && pin_out == mode_q[0])); // R1

    AST_CAPTURE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b00 && esel_q != 2'b00) |-> (!pin_oe && !pin_out)); // R2

    AST_CAPTURE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (chan_val == $past(cnt_val) && chan_flag)); // R3

    AST_OVERFLOW_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && tov_q && cnt_ovf && !full_act && !cfg_we) |=>
        (full_act || pin_out != $past(pin_out))); // R5

    AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (full_act && pin_oe) |-> pin_out); // R8

    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !cap_evt && !cmp_hit) |=> !chan_flag); // R9

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt || cmp_hit) |=> chan_flag); // R9
endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_val   (cnt_val),
    .cnt_ovf   (cnt_ovf),
    .cfg_we    (cfg_we),
    .flag_clr  (flag_clr),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .chan_flag (chan_flag),
    .chan_val  (chan_val),
    .mode_q    (cfg_q.mode),
    .esel_q    (esel_bits),
    .tov_q     (cfg_q.tov),
    .cap_evt   (cap_evt),
    .cmp_hit   (cmp_hit),
    .full_act  (full_act)
);

// File: tb/tmr_channel_bench.sv
// Self-checking bench: directed corners, then seeded random traffic,
// with every output compared against a bench model of the requirements.
module tmr_channel_bench;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] cnt_val;
    logic          cnt_ovf, cfg_we, cfg_tov, cfg_full, val_we, flag_clr, pin_in;
    logic [1:0]    cfg_mode, cfg_esel;
    logic [CW-1:0] val_wdata;
    logic          pin_out, pin_oe, chan_flag;
    logic [CW-1:0] chan_val;

    always #2 clk = ~clk;

    tmr_channel #(.CNT_W(CW)) u_tmr_channel (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_ovf(cnt_ovf),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_esel(cfg_esel),
        .cfg_tov(cfg_tov), .cfg_full(cfg_full), .val_we(val_we),
        .val_wdata(val_wdata), .flag_clr(flag_clr), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .chan_flag(chan_flag),
        .chan_val(chan_val)
    );

    // Bench model state.
    logic [1:0]    m_mode, m_esel;
    logic          m_tov, m_full, m_fact, m_pinq, m_flag, m_s1, m_s2, m_prev;
    logic [CW-1:0] m_val;
    int            n_cmp = 0;
    int            n_bad = 0;
    string         tag = "R10";

    function automatic logic f_outmode(logic [1:0] md, logic [1:0] es);
        return (es != 2'b00) && (md != 2'b00);
    endfunction

    function automatic logic f_pin(logic [1:0] md, logic [1:0] es, logic pq, logic fa);
        if (f_outmode(md, es)) return pq | fa;
        if (es == 2'b00)       return md[0];
        return 1'b0;
    endfunction

    task automatic check(string t, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    // Advance the model by one clock edge using the current inputs.
    task automatic model_tick();
        logic om, cm, rise, fall, cap, hit, npq;
        if (!rst_n) begin
            m_mode = 0; m_esel = 0; m_tov = 0; m_full = 0; m_fact = 0;
            m_pinq = 0; m_flag = 0; m_val = 0; m_s1 = 0; m_s2 = 0; m_prev = 0;
            return;
        end
        om   = f_outmode(m_mode, m_esel);
        cm   = (m_esel != 2'b00) && (m_mode == 2'b00);
        rise = m_s2 & ~m_prev;
        fall = ~m_s2 & m_prev;
        cap  = cm && ((m_esel[0] && rise) || (m_esel[1] && fall));
        hit  = om && (cnt_val == m_val);
        npq  = m_pinq;
        if (m_esel == 2'b00) npq = m_mode[0];
        else if (om) begin
            if (m_tov && cnt_ovf) npq = ~m_pinq;
            else if (hit) npq = (m_esel == 2'b01) ? ~m_pinq : (m_esel == 2'b11);
        end
        if (cnt_ovf) m_fact = m_full && m_tov && om;
        m_pinq = npq;
        if (cap) m_val = cnt_val; else if (val_we) m_val = val_wdata;
        if (cap || hit) m_flag = 1'b1; else if (flag_clr) m_flag = 1'b0;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
        if (cfg_we) begin
            m_mode = cfg_mode; m_esel = cfg_esel; m_tov = cfg_tov; m_full = cfg_full;
        end
    endtask

    // One clock: edge, model update, sample away from the edge, drop strobes.
    task automatic tick();
        @(posedge clk);
        model_tick();
        #1;
        check(tag, "pin_oe",    pin_oe,    f_outmode(m_mode, m_esel));
        check(tag, "pin_out",   pin_out,   f_pin(m_mode, m_esel, m_pinq, m_fact));
        check(tag, "chan_flag", chan_flag, m_flag);
        check(tag, "chan_val",  chan_val,  m_val);
        @(negedge clk);
        cfg_we = 0; val_we = 0; flag_clr = 0; cnt_ovf = 0;
    endtask

    task automatic set_cfg(logic [1:0] md, logic [1:0] es, logic tv, logic fd);
        cfg_we = 1; cfg_mode = md; cfg_esel = es; cfg_tov = tv; cfg_full = fd;
        tick();
    endtask

    task automatic set_val(logic [CW-1:0] v);
        val_we = 1; val_wdata = v;
        tick();
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 0; cnt_val = 16'hFFFF; cnt_ovf = 0; cfg_we = 0; cfg_mode = 0;
        cfg_esel = 0; cfg_tov = 0; cfg_full = 0; val_we = 0; val_wdata = 0;
        flag_clr = 0; pin_in = 0;
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        // R10: reset state
        tag = "R10";
        tick();
        check("R10", "reset pin_oe/out/flag", {pin_oe, pin_out, chan_flag}, 3'b000);

        // R1: preset level, then it seeds the output mode (R12 single load)
        tag = "R1";
        set_cfg(2'b01, 2'b00, 0, 0);
        check("R1", "preset high pin_out", pin_out, 1'b1);
        set_val(16'h0005);
        cnt_val = 16'h0001;
        tag = "R12";
        set_cfg(2'b01, 2'b01, 0, 0);
        check("R1", "start level in compare", {pin_oe, pin_out}, 2'b11);

        // R4: toggle / clear / set on match
        tag = "R4";
        cnt_val = 16'h0005; tick(); cnt_val = 16'h0001;
        check("R4", "toggle on match", {pin_out, chan_flag}, 2'b01);
        flag_clr = 1; tick();
        check("R9", "flag cleared", chan_flag, 1'b0);
        set_cfg(2'b10, 2'b11, 0, 0);
        cnt_val = 16'h0005; tick(); cnt_val = 16'h0001;
        check("R4", "set on match", pin_out, 1'b1);
        set_cfg(2'b11, 2'b10, 0, 0);
        cnt_val = 16'h0005; tick(); cnt_val = 16'h0001;
        check("R4", "clear on match", pin_out, 1'b0);

        // R9: clear strobe in a match cycle leaves the flag set
        tag = "R9";
        cnt_val = 16'h0005; flag_clr = 1; tick(); cnt_val = 16'h0001;
        check("R9", "set beats clear", chan_flag, 1'b1);

        // R5 / R6: overflow toggle, and overflow beating a clear match
        tag = "R5";
        set_cfg(2'b10, 2'b10, 1, 0);
        cnt_ovf = 1; tick();
        check("R5", "ovf toggles", pin_out, 1'b1);
        cnt_ovf = 1; tick();
        tag = "R6";
        cnt_val = 16'h0005; cnt_ovf = 1; tick(); cnt_val = 16'h0001;
        check("R6", "ovf wins over clear", {pin_out, chan_flag}, 2'b11);

        // R8: full duty starts and stops only at an overflow
        tag = "R8";
        cnt_val = 16'h0005; tick(); cnt_val = 16'h0001;
        check("R8", "normal clear before request", pin_out, 1'b0);
        set_cfg(2'b10, 2'b10, 1, 1);
        check("R8", "request not yet active", pin_out, 1'b0);
        cnt_ovf = 1; tick();
        cnt_val = 16'h0005; tick(); cnt_val = 16'h0001;
        check("R8", "forced high across match", pin_out, 1'b1);
        set_cfg(2'b10, 2'b10, 1, 0);
        cnt_val = 16'h0005; tick(); cnt_val = 16'h0001;
        check("R8", "still forced after clear", pin_out, 1'b1);
        cnt_ovf = 1; tick();
        cnt_val = 16'h0005; tick(); cnt_val = 16'h0001;
        check("R8", "released after next ovf", pin_out, 1'b0);

        // R7: overflows in capture mode leave output state as it was (0)
        tag = "R7";
        set_cfg(2'b00, 2'b01, 1, 0);
        repeat (3) begin cnt_ovf = 1; tick(); end
        cnt_val = 16'h0100;
        set_cfg(2'b01, 2'b01, 0, 0);
        check("R7", "state held through capture", pin_out, 1'b0);

        // R2 / R3: capture edges through the synchronizer
        tag = "R3";
        set_cfg(2'b00, 2'b01, 0, 0);
        flag_clr = 1; tick();
        cnt_val = 16'h0033; pin_in = 1; tick(); tick();
        check("R3", "no capture one edge early", chan_flag, 1'b0);
        tick();
        check("R3", "rising capture", {15'd0, chan_flag, chan_val}, {16'd1, 16'h0033});
        tag = "R2";
        flag_clr = 1; cnt_val = 16'h0044; pin_in = 0; tick(); tick(); tick(); tick();
        check("R2", "falling ignored in rising mode", {15'd0, chan_flag, chan_val}, {16'd0, 16'h0033});
        set_cfg(2'b00, 2'b11, 0, 0);
        cnt_val = 16'h0055; pin_in = 1; tick(); tick(); tick();
        check("R2", "both-edge capture rise", chan_val, 16'h0055);
        cnt_val = 16'h0066; pin_in = 0; tick(); tick(); tick();
        check("R2", "both-edge capture fall", chan_val, 16'h0066);

        // R11: capture collides with a value write
        tag = "R11";
        cnt_val = 16'h0077; pin_in = 1; tick(); tick();
        val_we = 1; val_wdata = 16'h0ABC; tick();
        check("R11", "capture beats write", chan_val, 16'h0077);
        set_val(16'h0123);
        check("R11", "plain write", chan_val, 16'h0123);

        // Seeded random traffic, all requirements via the model.
        tag = "R4";
        for (int i = 0; i < 6000; i++) begin
            cnt_val  = CW'($urandom % 8);
            cnt_ovf  = ($urandom % 6) == 0;
            pin_in   = ($urandom % 4) == 0 ? ~pin_in : pin_in;
            flag_clr = ($urandom % 5) == 0;
            val_we   = ($urandom % 30) == 0;
            val_wdata = CW'($urandom % 8);
            if (($urandom % 40) == 0) begin
                cfg_we = 1; cfg_mode = 2'($urandom); cfg_esel = 2'($urandom);
                cfg_tov = 1'($urandom); cfg_full = 1'($urandom);
            end
            if (($urandom % 500) == 0) rst_n = 0;
            tick();
            rst_n = 1;
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule